// File: doc/BRIEF.md
# Receive Loss-of-Signal Qualifier with Data Squelch

This block sits behind the peak comparators of a serial line receiver and decides when the line has really gone quiet and when it has really come back. Every unit interval (UI), the receiver reports two comparator results. One says the signal peak fell under the lower (assert) threshold. The other says the peak rose over the upper (clear) threshold, which lies about 1 dB higher. The gap between the two thresholds gives hysteresis. A loss indication is raised only after a run of consecutive UIs below the lower threshold. It is dropped only after an equal run of consecutive UIs above the upper threshold. The run length is a parameter and defaults to 110 UIs.

While loss is indicated, the block zeroes the recovered NRZ bits it forwards. It also drives a phase-hold output so that the clock recovery keeps its present phase tap. Monitor mode and local loopback each switch detection off. While either is on, the indication is forced low, both run counters are cleared and data passes unchanged.

The recovered bit stream enters with a valid strobe, one per UI, and leaves with a matching valid. The source is a line recovered at a fixed rate, which cannot be stalled, so the interface has no ready signal and accepts no back-pressure. Every input beat yields exactly one output beat one clock later. Cycles without a strobe are idle and change nothing.

Top module: `los_qualifier`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `los`, `phase_hold`, `nrz_vld` and `nrz_data` are all 0.
- R2: With detection enabled and `los` low, a UI counts toward assertion when `lvl_below`=1 and `lvl_above`=0. `los` rises at the clock edge that samples the RUN_UI-th consecutive such UI and not before.
- R3: With detection enabled and `los` high, a UI counts toward clearing when `lvl_above`=1 and `lvl_below`=0. `los` falls at the clock edge that samples the RUN_UI-th consecutive such UI and not before.
- R4: A UI that does not qualify restarts the run that is under way from zero. This includes a UI with neither flag set and a UI with both flags set. Such a UI leaves `los` unchanged.
- R5: Clock cycles with `ui_vld`=0 neither advance nor reset a run, and they never change `los`.
- R6: Each cycle with `ui_vld`=1 produces `nrz_vld`=1 in the next cycle. `nrz_data` then equals that UI's `ui_data`, except that it is 0 when `los` was high and detection was enabled in the strobe cycle. There is no ready and no back-pressure.
- R7: `phase_hold` is high exactly while `los` is high.
- R8: With `mon_en`=1 in a cycle, `los` is 0 after that cycle's edge, and both runs restart from zero once detection resumes.
- R9: With `lpbk_en`=1 in a cycle, `los` is 0 after that cycle's edge, and both runs restart from zero once detection resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| ui_vld | input | 1 | Strobe marking one unit interval; qualifies all UI inputs |
| ui_data | input | 1 | Recovered NRZ bit of this UI |
| lvl_below | input | 1 | Peak below the assert threshold in this UI |
| lvl_above | input | 1 | Peak above the clear threshold in this UI |
| mon_en | input | 1 | Receive monitor mode; disables detection |
| lpbk_en | input | 1 | Local loopback; disables detection |
| nrz_vld | output | 1 | Output beat valid, one cycle after `ui_vld` |
| nrz_data | output | 1 | Forwarded NRZ bit, squelched to 0 during loss |
| los | output | 1 | Qualified loss-of-signal indication |
| phase_hold | output | 1 | Tells clock recovery to keep its current phase tap |

## Verification
Every result of this block is due at the clock edge that samples the strobe or mode input causing it. The `los` and `phase_hold` transitions, the output beat and the effect of a disable input all become visible at the next falling edge. The bench drives each UI on a falling edge, lets one rising edge sample it, and reads the outputs on the following falling edge. In that way the 109th and 110th UIs of a run are each checked in their own cycle. Runs broken by idle gaps, by empty or conflicting flags, and by mode pulses are counted in the bench from the requirements, and the first squelched beat is expected one UI after `los` rises.

// File: rtl/los_pkg.sv
package los_pkg;

  // Classification of one UI's comparator flags.
  typedef enum logic [1:0] {
    LVL_NONE     = 2'd0,
    LVL_WEAK     = 2'd1,
    LVL_STRONG   = 2'd2,
    LVL_CONFLICT = 2'd3
  } lvl_e;

  // Run indices into the counter array.
  localparam int RUN_ASSERT = 0;
  localparam int RUN_CLEAR  = 1;
  localparam int RUN_COUNT  = 2;

  function automatic lvl_e classify(input logic below, input logic above);
    lvl_e r;
    unique case ({above, below})
      2'b01:   r = LVL_WEAK;
      2'b10:   r = LVL_STRONG;
      2'b11:   r = LVL_CONFLICT;
      default: r = LVL_NONE;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/los_run_counter.sv
module los_run_counter #(
  parameter int RUN_UI = 110,
  localparam int CW = (RUN_UI < 2) ? 1 : $clog2(RUN_UI)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  input  logic qual,
  output logic done
);

  localparam logic [CW-1:0] LAST = CW'(RUN_UI - 1);

  logic [CW-1:0] cnt;

  assign done = step && qual && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (step) begin
      if (!qual || cnt == LAST) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_RUN_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST) else $error("run counter beyond window"); // R2

  AST_IDLE_HOLDS_RUN: assert property (@(posedge clk) disable iff (rst)
    (!step && !clr) |=> $stable(cnt)) else $error("run moved without strobe"); // R5

  AST_BREAK_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    (step && !qual) |=> (cnt == '0)) else $error("broken run not restarted"); // R4

endmodule

// File: rtl/los_state_ctl.sv
module los_state_ctl
  import los_pkg::*;
#(
  parameter int RUN_UI = 110
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic det_en,
  input  lvl_e lvl,
  output logic lost
);

  logic [RUN_COUNT-1:0] qual;
  logic [RUN_COUNT-1:0] done;

  // A run only counts while the state it would leave is current.
  assign qual[RUN_ASSERT] = det_en && !lost && (lvl == LVL_WEAK);
  assign qual[RUN_CLEAR]  = det_en &&  lost && (lvl == LVL_STRONG);

  for (genvar g = 0; g < RUN_COUNT; g++) begin : g_run
    los_run_counter #(.RUN_UI(RUN_UI)) u_run (
      .clk  (clk),
      .rst  (rst),
      .clr  (!det_en),
      .step (step),
      .qual (qual[g]),
      .done (done[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst || !det_en) begin
      lost <= 1'b0;
    end else if (done[RUN_ASSERT]) begin
      lost <= 1'b1;
    end else if (done[RUN_CLEAR]) begin
      lost <= 1'b0;
    end
  end

  AST_RISE_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    $rose(lost) |-> $past(step && lvl == LVL_WEAK)) else $error("loss raised off a weak strobe"); // R2

  AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(lost) |-> ($past(!det_en) || $past(step && lvl == LVL_STRONG))) else $error("loss dropped without cause"); // R3

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !det_en |=> !lost) else $error("loss survived disable"); // R8

endmodule

// File: rtl/los_squelch_path.sv
module los_squelch_path (
  input  logic clk,
  input  logic rst,
  input  logic in_vld,
  input  logic in_data,
  input  logic squelch,
  output logic out_vld,
  output logic out_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_data <= 1'b0;
    end else begin
      out_vld  <= in_vld;
      out_data <= in_vld && in_data && !squelch;
    end
  end

  AST_BEAT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld) else $error("input beat dropped"); // R6

  AST_SQUELCH_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_vld && squelch) |=> !out_data) else $error("data leaked during loss"); // R6

endmodule

// File: rtl/los_qualifier.sv
module los_qualifier
  import los_pkg::*;
#(
  parameter int RUN_UI = 110
) (
  input  logic clk,
  input  logic rst,
  input  logic ui_vld,
  input  logic ui_data,
  input  logic lvl_below,
  input  logic lvl_above,
  input  logic mon_en,
  input  logic lpbk_en,
  output logic nrz_vld,
  output logic nrz_data,
  output logic los,
  output logic phase_hold
);

  logic det_en;
  logic lost;
  lvl_e lvl;

  assign det_en = !mon_en && !lpbk_en;
  assign lvl    = classify(lvl_below, lvl_above);

  los_state_ctl #(.RUN_UI(RUN_UI)) u_state (
    .clk    (clk),
    .rst    (rst),
    .step   (ui_vld),
    .det_en (det_en),
    .lvl    (lvl),
    .lost   (lost)
  );

  los_squelch_path u_path (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (ui_vld),
    .in_data  (ui_data),
    .squelch  (lost && det_en),
    .out_vld  (nrz_vld),
    .out_data (nrz_data)
  );

  assign los        = lost;
  assign phase_hold = lost;

  AST_LOOPBACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    lpbk_en |=> !los) else $error("loss survived loopback"); // R9

  AST_IDLE_KEEPS_LOS: assert property (@(posedge clk) disable iff (rst)
    (!ui_vld && det_en) |=> $stable(los)) else $error("loss moved without strobe"); // R5

  AST_HOLD_WITH_LOS: assert property (@(posedge clk) disable iff (rst)
    $rose(los) |-> phase_hold) else $error("phase hold missing"); // R7

endmodule

// File: tb/los_qualifier_bench.sv
module los_qualifier_bench;

  localparam int RUN = 110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ui_vld = 1'b0, ui_data = 1'b0, lvl_below = 1'b0, lvl_above = 1'b0;
  logic mon_en = 1'b0, lpbk_en = 1'b0;
  logic nrz_vld, nrz_data, los, phase_hold;

  int n_chk = 0;
  int n_bad = 0;
  logic model_los = 1'b0;

  always #5 clk = ~clk;

  los_qualifier #(.RUN_UI(RUN)) u_los_qualifier (
    .clk(clk), .rst(rst), .ui_vld(ui_vld), .ui_data(ui_data),
    .lvl_below(lvl_below), .lvl_above(lvl_above),
    .mon_en(mon_en), .lpbk_en(lpbk_en),
    .nrz_vld(nrz_vld), .nrz_data(nrz_data), .los(los), .phase_hold(phase_hold)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // One UI: drive at negedge, sampled at next posedge, checked at next negedge.
  task automatic ui(input logic b, input logic a, input logic d);
    logic exp_d;
    exp_d = d & ~(model_los & ~mon_en & ~lpbk_en);
    ui_vld = 1'b1; ui_data = d; lvl_below = b; lvl_above = a;
    @(negedge clk);
    ui_vld = 1'b0; ui_data = 1'b0; lvl_below = 1'b0; lvl_above = 1'b0;
    chk("R6 beat valid", nrz_vld, 1'b1);
    chk("R6 beat data", nrz_data, exp_d);
  endtask

  task automatic run(input int n, input logic b, input logic a);
    for (int i = 0; i < n; i++) ui(b, a, i[0]);
  endtask

  task automatic chk_los(input string tag, input logic exp);
    chk(tag, los, exp);
    chk("R7 phase hold", phase_hold, exp);
    model_los = exp;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 los in reset", los, 1'b0);
    chk("R1 hold in reset", phase_hold, 1'b0);
    chk("R1 vld in reset", nrz_vld, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 los after reset", los, 1'b0);
    chk("R1 data after reset", nrz_data, 1'b0);
    chk("R1 vld after reset", nrz_vld, 1'b0);
  endtask

  task automatic t_assert;
    run(RUN - 1, 1'b1, 1'b0);
    chk_los("R2 not yet at RUN-1", 1'b0);
    ui(1'b1, 1'b0, 1'b1);
    chk_los("R2 raised at RUN", 1'b1);
    @(negedge clk);
    chk("R6 no beat without strobe", nrz_vld, 1'b0);
    ui(1'b1, 1'b0, 1'b1);   // squelched: expected data 0
  endtask

  task automatic t_clear;
    run(RUN - 1, 1'b0, 1'b1);
    chk_los("R3 not yet at RUN-1", 1'b1);
    ui(1'b0, 1'b1, 1'b1);
    chk_los("R3 dropped at RUN", 1'b0);
    ui(1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_break;
    run(60, 1'b1, 1'b0);
    ui(1'b0, 1'b0, 1'b1);   // neither flag
    chk_los("R4 neither keeps low", 1'b0);
    run(RUN - 1, 1'b1, 1'b0);
    chk_los("R4 run restarted", 1'b0);
    ui(1'b1, 1'b0, 1'b0);
    chk_los("R4 full run after break", 1'b1);
    run(60, 1'b0, 1'b1);
    ui(1'b1, 1'b1, 1'b1);   // conflicting flags
    chk_los("R4 conflict keeps high", 1'b1);
    run(RUN - 1, 1'b0, 1'b1);
    chk_los("R4 clear run restarted", 1'b1);
    ui(1'b0, 1'b1, 1'b1);
    chk_los("R4 clear after break", 1'b0);
  endtask

  task automatic t_gap;
    run(55, 1'b1, 1'b0);
    repeat (20) @(negedge clk);
    chk_los("R5 idle keeps low", 1'b0);
    run(54, 1'b1, 1'b0);
    chk_los("R5 gaps not counted early", 1'b0);
    ui(1'b1, 1'b0, 1'b1);
    chk_los("R5 run spans gap", 1'b1);
    repeat (30) @(negedge clk);
    chk_los("R5 idle keeps high", 1'b1);
  endtask

  task automatic t_mode(input bit use_mon, input string tag);
    // los is high on entry
    if (use_mon) mon_en = 1'b1; else lpbk_en = 1'b1;
    @(negedge clk);
    chk_los({tag, " disable clears los"}, 1'b0);
    run(2 * RUN, 1'b1, 1'b0);
    chk_los({tag, " no detection while disabled"}, 1'b0);
    mon_en = 1'b0; lpbk_en = 1'b0;
    run(50, 1'b1, 1'b0);
    if (use_mon) mon_en = 1'b1; else lpbk_en = 1'b1;
    @(negedge clk);
    mon_en = 1'b0; lpbk_en = 1'b0;
    run(RUN - 1, 1'b1, 1'b0);
    chk_los({tag, " run reset by pulse"}, 1'b0);
    ui(1'b1, 1'b0, 1'b1);
    chk_los({tag, " detection resumes"}, 1'b1);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_assert();
    t_clear();
    t_break();
    t_gap();
    t_mode(1'b1, "R8");
    t_mode(1'b0, "R9");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule